// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block turns a flat panel on or off in a fixed order. A one-clock start pulse launches a run and carries a direction bit: 1 means power up and 0 means power down. The run drives three enables one after another, in this order: panel enable, then data enable, then bias enable. A fourth step writes the panel enable again with the value it already holds. After every step the block waits a programmable number of vertical sync periods before it moves on.

The block counts vsync periods itself, so it needs no software polling. The vsync status is first brought into the clock domain through two flops. One period counts when the synchronized vsync has been seen inactive and then becomes active again. The delay count is a parallel input. A value of 4 is the usual setting.

If the pixel PLL is off, or the timing generator is disabled, no vsync will arrive. In that case every wait ends at once, so a run can never hang. A delay of 0 also removes the wait: the run advances one step per clock.

Top module: `panel_pwr_seq`

## Requirements
- R1: Each step drives its signal to the direction value captured at start, in this fixed order: panel enable on the start edge, then data enable, then bias enable, then a rewrite of panel enable with its current value.
- R2: With the delay set to D > 0, and with the PLL and timing flags both high, each step after the first comes D vsync periods after the step before it. One period is the synchronized vsync going inactive and then active again after the previous step. If vsync is active when a step is applied, it must first fall before a period can count.
- R3: With the delay at 0 and no bypass, the run advances on every clock. Panel enable changes on the start edge, data enable one clock later and bias enable two clocks later. The settle step takes effect three clocks after start.
- R4: While the PLL flag or the timing flag is low, every wait completes at once. The run then has the same cycle timing as in R3, whatever the delay input holds.
- R5: done_o is high for exactly one clock, four step times after start. In that same clock busy_o falls. busy_o is high from the clock after the start edge until done.
- R6: A start pulse that arrives while busy_o is high is ignored. The run continues in its original direction and produces a single done pulse.
- R7: After reset all three enables, busy_o and done_o are 0.
- R8: While the block is idle and no start is given, the three enables hold their values, whatever vsync, the direction bit or the flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a sequence |
| dir_i | input | 1 | Direction: 1 for power up, 0 for power down; captured with start |
| delay_i | input | DLY_W | Vsync periods to wait after each step; captured with start |
| vsync_i | input | 1 | Vsync status, asynchronous; 1 means active |
| pll_on_i | input | 1 | Pixel PLL powered |
| timing_on_i | input | 1 | Timing generator enabled |
| panel_en_o | output | 1 | Panel enable |
| data_en_o | output | 1 | Panel data enable |
| bias_en_o | output | 1 | Panel bias enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse when a sequence ends |

## Verification
The bench uses the default parameters: a 4-bit delay and a two-stage synchronizer. With these, both a zero delay and the largest delay of 15 can be reached. The largest delay is only exercised under the PLL or timing bypass, where it must have no effect. In the vsync-paced case the bench uses a delay of 2. Each vsync period is 16 clocks long, which leaves room for the synchronizer latency on either side of a check. This shows both the counting of full inactive-then-active periods and the step that must wait while vsync is already active.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} pps_state_t;

  // Step order is behaviour: the enables must come up in this sequence.
  typedef enum logic [1:0] {
    STP_PANEL  = 2'd0,
    STP_DATA   = 2'd1,
    STP_BIAS   = 2'd2,
    STP_SETTLE = 2'd3
  } pps_step_t;

  function automatic pps_step_t step_after(pps_step_t s);
    return pps_step_t'(s + 2'd1);
  endfunction

  function automatic logic is_final(pps_step_t s);
    return s == STP_SETTLE;
  endfunction
endpackage

// File: rtl/pps_vsync_sync.sv
module pps_vsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic vs_sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= vsync_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign vs_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pps_period_cnt.sv
module pps_period_cnt #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             vs_sync_i,
  input  logic             bypass_i,
  output logic             tick_o,
  output logic             expired_o
);
  logic [DLY_W-1:0] rem_q;
  logic             seen_low_q;

  // a period completes when vsync is active after an inactive phase
  assign tick_o    = seen_low_q & vs_sync_i & ~load_i & (rem_q != '0);
  assign expired_o = bypass_i | (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      seen_low_q <= 1'b0;
    end else if (load_i) begin
      rem_q      <= load_val_i;
      seen_low_q <= 1'b0;
    end else begin
      if (tick_o) rem_q <= rem_q - 1'b1;
      seen_low_q <= tick_o ? 1'b0 : (seen_low_q | ~vs_sync_i);
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned DLY_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             vsync_i,
  input  logic             pll_on_i,
  input  logic             timing_on_i,
  output logic             panel_en_o,
  output logic             data_en_o,
  output logic             bias_en_o,
  output logic             busy_o,
  output logic             done_o
);
  pps_state_t       state_q;
  pps_step_t        step_q, step_nxt;
  logic             dir_q, dir_eff;
  logic [DLY_W-1:0] dly_q, dly_eff;
  logic             panel_q, data_q, bias_q, done_q;

  // named internal events
  logic vs_sync, period_tick, wait_over, bypass;
  logic accept, step_fire, finish;

  assign bypass    = ~pll_on_i | ~timing_on_i;
  assign accept    = (state_q == ST_IDLE) & start_i;
  assign step_fire = accept | ((state_q == ST_WAIT) & wait_over & ~is_final(step_q));
  assign finish    = (state_q == ST_WAIT) & wait_over & is_final(step_q);
  assign step_nxt  = accept ? STP_PANEL : step_after(step_q);
  assign dir_eff   = accept ? dir_i : dir_q;
  assign dly_eff   = accept ? delay_i : dly_q;

  pps_vsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_i   (vsync_i),
    .vs_sync_o (vs_sync)
  );

  pps_period_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (step_fire),
    .load_val_i (dly_eff),
    .vs_sync_i  (vs_sync),
    .bypass_i   (bypass),
    .tick_o     (period_tick),
    .expired_o  (wait_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STP_PANEL;
      dir_q   <= 1'b0;
      dly_q   <= '0;
      panel_q <= 1'b0;
      data_q  <= 1'b0;
      bias_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        dir_q   <= dir_i;
        dly_q   <= delay_i;
        state_q <= ST_WAIT;
      end
      if (finish) state_q <= ST_IDLE;
      if (step_fire) begin
        step_q <= step_nxt;
        unique case (step_nxt)
          STP_PANEL:  panel_q <= dir_eff;
          STP_DATA:   data_q  <= dir_eff;
          STP_BIAS:   bias_q  <= dir_eff;
          STP_SETTLE: panel_q <= dir_eff;  // same value, one more interval
          default:    ;
        endcase
      end
    end
  end

  assign panel_en_o = panel_q;
  assign data_en_o  = data_q;
  assign bias_en_o  = bias_q;
  assign busy_o     = (state_q == ST_WAIT);
  assign done_o     = done_q;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic panel_en_o,
  input logic data_en_o,
  input logic bias_en_o,
  input logic busy_o,
  input logic done_o,
  input logic period_tick,
  input logic vs_sync
);
  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R1
  data_after_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_en_o) |-> (data_en_o == panel_en_o));
  // R1
  bias_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_en_o) |-> (bias_en_o == data_en_o));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(panel_en_o) && $stable(data_en_o) && $stable(bias_en_o)));
  // R2
  tick_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> vs_sync);
endmodule

bind panel_pwr_seq pps_chk u_pps_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .panel_en_o  (panel_en_o),
  .data_en_o   (data_en_o),
  .bias_en_o   (bias_en_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .period_tick (period_tick),
  .vs_sync     (vs_sync)
);

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;
  localparam int DLY_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0, vsync_i = 1'b0;
  logic pll_on_i = 1'b1, timing_on_i = 1'b1;
  logic [DLY_W-1:0] delay_i = '0;
  logic panel_en_o, data_en_o, bias_en_o, busy_o, done_o;

  int n_vec = 0, n_bad = 0, done_cnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  panel_pwr_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .delay_i(delay_i), .vsync_i(vsync_i), .pll_on_i(pll_on_i),
    .timing_on_i(timing_on_i), .panel_en_o(panel_en_o),
    .data_en_o(data_en_o), .bias_en_o(bias_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (panel,data,bias,busy,done)", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {panel_en_o, data_en_o, bias_en_o, busy_o, done_o};
  endfunction

  task automatic pulse_start(logic d, logic [DLY_W-1:0] dl);
    dir_i = d; delay_i = dl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic vs_period();
    vsync_i = 1'b0;
    repeat (8) @(negedge clk);
    vsync_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // {dir, delay[3:0], pll_on, timing_on}
  localparam logic [6:0] VEC [0:5] = '{
    {1'b1, 4'd0,  1'b1, 1'b1},
    {1'b0, 4'd0,  1'b1, 1'b1},
    {1'b1, 4'd5,  1'b0, 1'b1},
    {1'b0, 4'd3,  1'b1, 1'b0},
    {1'b1, 4'd15, 1'b0, 1'b0},
    {1'b1, 4'd0,  1'b1, 1'b1}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic ep, ed, eb;
    repeat (3) @(negedge clk);
    chk("R7 reset", outs(), 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", outs(), 5'b00000);

    // table: zero delay or bypass, fixed clock timing
    ep = 1'b0; ed = 1'b0; eb = 1'b0;
    for (int v = 0; v < 6; v++) begin
      logic d;
      d = VEC[v][6];
      pll_on_i = VEC[v][1]; timing_on_i = VEC[v][0];
      dir_i = d; delay_i = VEC[v][5:2];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < 6; c++) begin
        logic [4:0] e;
        e = {d, (c >= 1) ? d : ed, (c >= 2) ? d : eb, c <= 3, c == 4};
        chk((VEC[v][1] & VEC[v][0]) ? "R3 R1 zero delay" : "R4 R1 bypass", outs(), e);
        @(negedge clk);
      end
      ep = d; ed = d; eb = d;
    end

    // R8: idle with vsync toggling and inputs moving, no start
    pll_on_i = 1'b1; timing_on_i = 1'b1; dir_i = 1'b0;
    vs_period(); vs_period();
    chk("R8 idle hold", outs(), {ep, ed, eb, 2'b00});

    // power down first so the vsync test starts from all zero
    pulse_start(1'b0, 4'd0);
    repeat (6) @(negedge clk);
    chk("R1 power down", outs(), 5'b00000);

    // R2 vsync paced, delay 2, vsync already active at start
    done_cnt = 0;
    vsync_i = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start(1'b1, 4'd2);
    chk("R1 panel first", outs(), 5'b10010);
    repeat (20) @(negedge clk);
    chk("R2 no count while active", outs(), 5'b10010);
    vs_period();
    chk("R2 one period", outs(), 5'b10010);
    pulse_start(1'b0, 4'd0);  // R6 ignored while busy
    chk("R6 start ignored", outs(), 5'b10010);
    vs_period();
    chk("R2 data after two periods", outs(), 5'b11010);
    vs_period(); vs_period();
    chk("R2 bias after two more", outs(), 5'b11110);
    vs_period(); vs_period();
    chk("R2 settle still busy", outs(), 5'b11110);
    vs_period();
    chk("R2 one period short", outs(), 5'b11110);
    vs_period();
    chk("R5 R6 finished up", outs(), 5'b11100);
    chk("R5 single done", {4'b0, done_cnt == 1}, 5'b00001);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule